// File: doc/BRIEF.md
# Timer Compare-Value Access Router

This block sits beside the system-register access path of a processor core and handles reads and writes aimed at two timer compare-value encodings. The first encoding names the secure hypervisor virtual compare register. The second is the virtual compare encoding that EL0 software can see. For each valid request the block takes the current exception level and a set of configuration bits. From these it settles on one outcome: undefined, a trap to EL1 or EL2 with syndrome class 0x18, a redirect to a memory offset, or an access to one of three physical 64-bit compare registers.

The EL0-visible encoding is not a fixed permission check. It is quietly routed to one of three physical registers, or to memory, depending on the host-mode, nested-virtualization, register-width and security bits. The block only emits the memory redirect as a request. Timer counting happens elsewhere.

Reads return the selected register in the same cycle. A write lands on the next clock edge, and only when the outcome is a register access.

Top module: `tmr_cmp_router`

## Requirements
- R1: A request matches the secure hypervisor encoding when op0=3, op1=4, CRn=14, CRm=4 and op2=2. It matches the EL0 encoding when op0=3, op1=3, CRn=14, CRm=3 and op2=2. Any other encoding, or req_valid=0, asserts no outcome.
- R2: At most one of out_undef, out_trap, out_mem and out_reg is high in any cycle, and none is high while req_valid=0.
- R3: Every EL0 access to the secure hypervisor encoding is undefined.
- R4: For an EL1 access to the secure hypervisor encoding, the checks apply in this order. If el3_present=1 and ns_state=1, it is undefined. Otherwise, if hyp_en=1 and nest_v=1, it traps to EL2. Otherwise it is undefined.
- R5: An EL2 access to the secure hypervisor encoding is undefined when el3_present=1 and ns_state=1. In every other case it reaches register select 1 (secure hypervisor compare).
- R6: An EL3 access to the secure hypervisor encoding is undefined when sec_hyp_en=0. When sec_hyp_en=1 it reaches register select 1.
- R7: An EL0 access to the EL0 encoding traps when el1_a32=0, k_vt_en=0, and hyp_en and host mode (host_ext=1 and host_route=1) are not both set. The trap goes to EL2 (trap_to_hyp=1) when hyp_en=1, hyp_a32=0 and host_route=1. Otherwise it goes to EL1 (trap_to_hyp=0). When none of the traps in R7 and R8 applies and the R8 host condition does not hold, the access reaches register select 0 (EL0 virtual compare).
- R8: If R7 does not trap, and hyp_en=1, hyp_a32=0 and host mode is on, an EL0 access to the EL0 encoding behaves as follows. With h_vt_en=0 it traps to EL2. Otherwise it reaches select 1 when ns_state=0 and select 2 (non-secure hypervisor compare) when ns_state=1.
- R9: An EL1 access to the EL0 encoding is redirected to memory at offset 0x168 when hyp_en=1, hyp_a32=0 and nest_v, nest_v1 and nest_v2 are all 1. In that case mem_write follows req_write and mem_wdata carries the write data. Otherwise the access reaches select 0.
- R10: An EL2 access to the EL0 encoding reaches select 0 when host_ext=0. With host_ext=1 it reaches select 1 when ns_state=0 and select 2 when ns_state=1.
- R11: An EL3 access to the EL0 encoding always reaches select 0.
- R12: A write changes the selected register at the next clock edge only when out_reg is high. Undefined, trapped, redirected and idle writes leave all registers unchanged. A read with out_reg high returns the selected register in the same cycle. In all other cases rdata is zero.
- R13: Synchronous active-high reset clears all three compare registers to zero.
- R14: Every trap reports trap_class = 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_wdata | input | 64 | Write data |
| cur_el | input | 2 | Current exception level |
| el3_present | input | 1 | EL3 implemented |
| ns_state | input | 1 | Non-secure state bit |
| sec_hyp_en | input | 1 | Secure EL2 enabled from EL3 |
| hyp_en | input | 1 | EL2 enabled in current state |
| host_ext | input | 1 | Hypervisor host extension enable |
| host_route | input | 1 | Route EL0 exceptions to EL2 |
| nest_v | input | 1 | Nested virtualization enable |
| nest_v1 | input | 1 | Nested virtualization control 1 |
| nest_v2 | input | 1 | Nested virtualization memory redirect |
| k_vt_en | input | 1 | Kernel-level EL0 virtual timer access enable |
| h_vt_en | input | 1 | Hypervisor-level EL0 virtual timer access enable |
| el1_a32 | input | 1 | EL1 uses 32-bit execution |
| hyp_a32 | input | 1 | EL2 uses 32-bit execution |
| out_undef | output | 1 | Outcome: undefined |
| out_trap | output | 1 | Outcome: trap |
| trap_to_hyp | output | 1 | Trap target: 1 = EL2, 0 = EL1 |
| trap_class | output | 6 | Trap syndrome class |
| out_mem | output | 1 | Outcome: memory redirect |
| mem_offset | output | 12 | Redirect offset |
| mem_write | output | 1 | Redirect is a write |
| mem_wdata | output | 64 | Redirect write data |
| out_reg | output | 1 | Outcome: register access |
| reg_sel | output | 2 | Selected register (0 EL0, 1 secure hyp, 2 non-secure hyp) |
| rdata | output | 64 | Read data |

## Verification
Some rules are checked by the assertions on every cycle: that outcomes are mutually exclusive and silent when idle, that EL0 can never reach the secure hypervisor encoding, that EL1 never reaches a register through it, that EL3 on the EL0 encoding always lands on select 0, and that an enabled write lands in the chosen register. Other behaviour only the bench scenarios can show. That covers the full priority chains of the EL0 and EL1 trap and redirect decisions, the trap target, and the three-way routing under host mode and security state. It also covers whether rejected writes really leave every register untouched, read back through the normal port.

// File: rtl/tcr_pkg.sv
package tcr_pkg;

  localparam logic [1:0] ENC_OP0     = 2'b11;
  localparam logic [3:0] ENC_CRN     = 4'b1110;
  localparam logic [2:0] ENC_OP2     = 3'b010;
  localparam logic [2:0] ENC_HYP_OP1 = 3'b100;
  localparam logic [3:0] ENC_HYP_CRM = 4'b0100;
  localparam logic [2:0] ENC_E0_OP1  = 3'b011;
  localparam logic [3:0] ENC_E0_CRM  = 4'b0011;

  typedef enum logic [2:0] {
    OC_NONE  = 3'd0,
    OC_UNDEF = 3'd1,
    OC_TRAP  = 3'd2,
    OC_MEM   = 3'd3,
    OC_REG   = 3'd4
  } outcome_e;

  typedef enum logic [1:0] {
    SEL_E0   = 2'd0,
    SEL_HSEC = 2'd1,
    SEL_HNS  = 2'd2
  } sel_e;

  typedef struct packed {
    logic el3_present;
    logic ns_state;
    logic sec_hyp_en;
    logic hyp_en;
    logic host_ext;
    logic host_route;
    logic nest_v;
    logic nest_v1;
    logic nest_v2;
    logic k_vt_en;
    logic h_vt_en;
    logic el1_a32;
    logic hyp_a32;
  } cfg_t;

endpackage

// File: rtl/tcr_decode.sv
module tcr_decode
  import tcr_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output logic       hit_hyp,
  output logic       hit_e0
);
  logic common;

  assign common  = valid && (op0 == ENC_OP0) && (crn == ENC_CRN) && (op2 == ENC_OP2);
  assign hit_hyp = common && (op1 == ENC_HYP_OP1) && (crm == ENC_HYP_CRM);
  assign hit_e0  = common && (op1 == ENC_E0_OP1) && (crm == ENC_E0_CRM);
endmodule

// File: rtl/tcr_policy.sv
module tcr_policy
  import tcr_pkg::*;
(
  input  logic [1:0] el,
  input  logic       hit_hyp,
  input  logic       hit_e0,
  input  cfg_t       c,
  output outcome_e   oc,
  output logic       to_hyp,
  output sel_e       sel
);
  logic host;
  logic host64;
  logic hyp64;
  logic nest_all;
  sel_e hyp_pick;

  assign host     = c.host_ext && c.host_route;
  assign hyp64    = c.hyp_en && !c.hyp_a32;
  assign host64   = hyp64 && host;
  assign nest_all = c.nest_v && c.nest_v1 && c.nest_v2;
  assign hyp_pick = c.ns_state ? SEL_HNS : SEL_HSEC;

  always_comb begin
    oc     = OC_NONE;
    to_hyp = 1'b0;
    sel    = SEL_E0;
    if (hit_hyp) begin
      unique case (el)
        2'd0: oc = OC_UNDEF;
        2'd1: begin
          if (c.el3_present && c.ns_state) begin
            oc = OC_UNDEF;
          end else if (c.hyp_en && c.nest_v) begin
            oc     = OC_TRAP;
            to_hyp = 1'b1;
          end else begin
            oc = OC_UNDEF;
          end
        end
        2'd2: begin
          if (c.el3_present && c.ns_state) begin
            oc = OC_UNDEF;
          end else begin
            oc  = OC_REG;
            sel = SEL_HSEC;
          end
        end
        default: begin
          if (!c.sec_hyp_en) begin
            oc = OC_UNDEF;
          end else begin
            oc  = OC_REG;
            sel = SEL_HSEC;
          end
        end
      endcase
    end else if (hit_e0) begin
      unique case (el)
        2'd0: begin
          if (!c.el1_a32 && !(c.hyp_en && host) && !c.k_vt_en) begin
            oc     = OC_TRAP;
            to_hyp = hyp64 && c.host_route;
          end else if (host64 && !c.h_vt_en) begin
            oc     = OC_TRAP;
            to_hyp = 1'b1;
          end else if (host64) begin
            oc  = OC_REG;
            sel = hyp_pick;
          end else begin
            oc = OC_REG;
          end
        end
        2'd1: begin
          if (hyp64 && nest_all) oc = OC_MEM;
          else                   oc = OC_REG;
        end
        2'd2: begin
          oc  = OC_REG;
          sel = c.host_ext ? hyp_pick : SEL_E0;
        end
        default: oc = OC_REG;
      endcase
    end
  end
endmodule

// File: rtl/tcr_regs.sv
module tcr_regs #(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 3,
  localparam int SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  wsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SEL_W-1:0]  rsel,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] bank [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        bank[i] <= '0;
      end else if (we && (wsel == SEL_W'(i))) begin
        bank[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rsel == SEL_W'(i)) rdata = bank[i];
    end
  end

  // R12: an enabled write is visible in the chosen register one edge later
  p_write_lands_r12: assert property (@(posedge clk) disable iff (rst)
    (we && (int'(wsel) < NUM_REGS)) |=> bank[$past(wsel)] == $past(wdata));

  // R13: reset leaves the first register cleared
  p_reset_clear_r13: assert property (@(posedge clk)
    rst |=> bank[0] == '0);
endmodule

// File: rtl/tmr_cmp_router.sv
module tmr_cmp_router
  import tcr_pkg::*;
#(
  parameter int          DATA_W   = 64,
  parameter int          NUM_REGS = 3,
  parameter int          OFF_W    = 12,
  parameter int          EC_W     = 6,
  parameter logic [11:0] MEM_OFF  = 12'h168,
  parameter logic [5:0]  TRAP_EC  = 6'h18,
  localparam int         SEL_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_op0,
  input  logic [2:0]        req_op1,
  input  logic [3:0]        req_crn,
  input  logic [3:0]        req_crm,
  input  logic [2:0]        req_op2,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        cur_el,
  input  logic              el3_present,
  input  logic              ns_state,
  input  logic              sec_hyp_en,
  input  logic              hyp_en,
  input  logic              host_ext,
  input  logic              host_route,
  input  logic              nest_v,
  input  logic              nest_v1,
  input  logic              nest_v2,
  input  logic              k_vt_en,
  input  logic              h_vt_en,
  input  logic              el1_a32,
  input  logic              hyp_a32,
  output logic              out_undef,
  output logic              out_trap,
  output logic              trap_to_hyp,
  output logic [EC_W-1:0]   trap_class,
  output logic              out_mem,
  output logic [OFF_W-1:0]  mem_offset,
  output logic              mem_write,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              out_reg,
  output logic [SEL_W-1:0]  reg_sel,
  output logic [DATA_W-1:0] rdata
);
  cfg_t              cfg;
  logic              hit_hyp;
  logic              hit_e0;
  outcome_e          oc;
  logic              to_hyp;
  sel_e              sel;
  logic [DATA_W-1:0] bank_rdata;

  assign cfg = '{el3_present: el3_present, ns_state: ns_state, sec_hyp_en: sec_hyp_en,
                 hyp_en: hyp_en, host_ext: host_ext, host_route: host_route,
                 nest_v: nest_v, nest_v1: nest_v1, nest_v2: nest_v2,
                 k_vt_en: k_vt_en, h_vt_en: h_vt_en, el1_a32: el1_a32, hyp_a32: hyp_a32};

  tcr_decode u_dec (
    .valid   (req_valid),
    .op0     (req_op0),
    .op1     (req_op1),
    .crn     (req_crn),
    .crm     (req_crm),
    .op2     (req_op2),
    .hit_hyp (hit_hyp),
    .hit_e0  (hit_e0)
  );

  tcr_policy u_pol (
    .el      (cur_el),
    .hit_hyp (hit_hyp),
    .hit_e0  (hit_e0),
    .c       (cfg),
    .oc      (oc),
    .to_hyp  (to_hyp),
    .sel     (sel)
  );

  tcr_regs #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (out_reg && req_write),
    .wsel  (SEL_W'(sel)),
    .wdata (req_wdata),
    .rsel  (SEL_W'(sel)),
    .rdata (bank_rdata)
  );

  assign out_undef   = (oc == OC_UNDEF);
  assign out_trap    = (oc == OC_TRAP);
  assign out_mem     = (oc == OC_MEM);
  assign out_reg     = (oc == OC_REG);
  assign trap_to_hyp = out_trap && to_hyp;
  assign trap_class  = out_trap ? EC_W'(TRAP_EC) : '0;
  assign mem_offset  = out_mem ? OFF_W'(MEM_OFF) : '0;
  assign mem_write   = out_mem && req_write;
  assign mem_wdata   = out_mem ? req_wdata : '0;
  assign reg_sel     = out_reg ? SEL_W'(sel) : '0;
  assign rdata       = (out_reg && !req_write) ? bank_rdata : '0;

  // R2: outcomes are mutually exclusive
  p_one_outcome_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_undef, out_trap, out_mem, out_reg}));

  // R2: no outcome without a request
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !(out_undef || out_trap || out_mem || out_reg));

  // R3: EL0 never reaches the secure hypervisor encoding
  p_el0_hyp_undef_r3: assert property (@(posedge clk) disable iff (rst)
    (hit_hyp && cur_el == 2'd0) |-> out_undef);

  // R4: EL1 never reaches a register or memory through the secure hypervisor encoding
  p_el1_hyp_blocked_r4: assert property (@(posedge clk) disable iff (rst)
    (hit_hyp && cur_el == 2'd1) |-> (out_undef || (out_trap && trap_to_hyp)));

  // R11: EL3 on the EL0 encoding lands on select 0
  p_el3_e0_reg_r11: assert property (@(posedge clk) disable iff (rst)
    (hit_e0 && cur_el == 2'd3) |-> (out_reg && reg_sel == 2'd0));
endmodule

// File: tb/tb_tmr_cmp_router.sv
`timescale 1ns/1ps
module tb_tmr_cmp_router;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [1:0]  req_op0;
  logic [2:0]  req_op1;
  logic [3:0]  req_crn, req_crm;
  logic [2:0]  req_op2;
  logic [63:0] req_wdata;
  logic [1:0]  cur_el;
  logic [12:0] cfgv;
  logic        out_undef, out_trap, trap_to_hyp, out_mem, mem_write, out_reg;
  logic [5:0]  trap_class;
  logic [11:0] mem_offset;
  logic [63:0] mem_wdata, rdata;
  logic [1:0]  reg_sel;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  tmr_cmp_router dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
    .req_op2(req_op2), .req_wdata(req_wdata), .cur_el(cur_el),
    .el3_present(cfgv[12]), .ns_state(cfgv[11]), .sec_hyp_en(cfgv[10]),
    .hyp_en(cfgv[9]), .host_ext(cfgv[8]), .host_route(cfgv[7]),
    .nest_v(cfgv[6]), .nest_v1(cfgv[5]), .nest_v2(cfgv[4]),
    .k_vt_en(cfgv[3]), .h_vt_en(cfgv[2]), .el1_a32(cfgv[1]), .hyp_a32(cfgv[0]),
    .out_undef(out_undef), .out_trap(out_trap), .trap_to_hyp(trap_to_hyp),
    .trap_class(trap_class), .out_mem(out_mem), .mem_offset(mem_offset),
    .mem_write(mem_write), .mem_wdata(mem_wdata), .out_reg(out_reg),
    .reg_sel(reg_sel), .rdata(rdata)
  );

  // cfg bits, msb first: el3p ns shen | hen hext hrte | nv nv1 nv2 | ken hven | a32el1 a32el2
  // enc: 0 other, 1 secure hyp, 2 EL0 view. oc: 0 none 1 undef 2 trap 3 mem 4 reg
  typedef struct packed {
    logic [1:0]  el;
    logic [1:0]  enc;
    logic [12:0] cfg;
    logic [2:0]  oc;
    logic        tgt;
    logic [1:0]  sel;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd1, 13'b000_000_000_00_00, 3'd1, 1'b0, 2'd0, 4'd3},  // R3
    '{2'd1, 2'd1, 13'b110_100_100_00_00, 3'd1, 1'b0, 2'd0, 4'd4},  // R4
    '{2'd1, 2'd1, 13'b100_100_100_00_00, 3'd2, 1'b1, 2'd0, 4'd4},  // R4
    '{2'd1, 2'd1, 13'b100_000_100_00_00, 3'd1, 1'b0, 2'd0, 4'd4},  // R4
    '{2'd1, 2'd1, 13'b010_100_100_00_00, 3'd2, 1'b1, 2'd0, 4'd4},  // R4
    '{2'd2, 2'd1, 13'b110_000_000_00_00, 3'd1, 1'b0, 2'd0, 4'd5},  // R5
    '{2'd2, 2'd1, 13'b010_000_000_00_00, 3'd4, 1'b0, 2'd1, 4'd5},  // R5
    '{2'd3, 2'd1, 13'b100_000_000_00_00, 3'd1, 1'b0, 2'd0, 4'd6},  // R6
    '{2'd3, 2'd1, 13'b101_000_000_00_00, 3'd4, 1'b0, 2'd1, 4'd6},  // R6
    '{2'd0, 2'd2, 13'b000_101_000_00_00, 3'd2, 1'b1, 2'd0, 4'd7},  // R7
    '{2'd0, 2'd2, 13'b000_000_000_00_00, 3'd2, 1'b0, 2'd0, 4'd7},  // R7
    '{2'd0, 2'd2, 13'b000_101_000_00_01, 3'd2, 1'b0, 2'd0, 4'd7},  // R7
    '{2'd0, 2'd2, 13'b000_000_000_10_00, 3'd4, 1'b0, 2'd0, 4'd7},  // R7
    '{2'd0, 2'd2, 13'b000_000_000_00_10, 3'd4, 1'b0, 2'd0, 4'd7},  // R7
    '{2'd0, 2'd2, 13'b000_111_000_00_00, 3'd2, 1'b1, 2'd0, 4'd8},  // R8
    '{2'd0, 2'd2, 13'b000_111_000_01_00, 3'd4, 1'b0, 2'd1, 4'd8},  // R8
    '{2'd0, 2'd2, 13'b010_111_000_01_00, 3'd4, 1'b0, 2'd2, 4'd8},  // R8
    '{2'd0, 2'd2, 13'b000_111_000_00_01, 3'd4, 1'b0, 2'd0, 4'd8},  // R8
    '{2'd1, 2'd2, 13'b000_100_111_00_00, 3'd3, 1'b0, 2'd0, 4'd9},  // R9
    '{2'd1, 2'd2, 13'b000_100_110_00_00, 3'd4, 1'b0, 2'd0, 4'd9},  // R9
    '{2'd1, 2'd2, 13'b000_100_111_00_01, 3'd4, 1'b0, 2'd0, 4'd9},  // R9
    '{2'd2, 2'd2, 13'b000_010_000_00_00, 3'd4, 1'b0, 2'd1, 4'd10}, // R10
    '{2'd2, 2'd2, 13'b010_010_000_00_00, 3'd4, 1'b0, 2'd2, 4'd10}, // R10
    '{2'd2, 2'd2, 13'b010_000_000_00_00, 3'd4, 1'b0, 2'd0, 4'd10}, // R10
    '{2'd3, 2'd2, 13'b111_111_111_00_00, 3'd4, 1'b0, 2'd0, 4'd11}, // R11
    '{2'd2, 2'd0, 13'b010_010_000_00_00, 3'd0, 1'b0, 2'd0, 4'd1}   // R1
  };

  function automatic int act_oc();
    int n = int'(out_undef) + int'(out_trap) + int'(out_mem) + int'(out_reg);
    if (n > 1)     return 7;
    if (out_undef) return 1;
    if (out_trap)  return 2;
    if (out_mem)   return 3;
    if (out_reg)   return 4;
    return 0;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] el, input logic [1:0] enc, input logic [12:0] cfg,
                       input logic wr, input logic [63:0] data);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_op0   = 2'b11;
    req_crn   = 4'b1110;
    req_op2   = 3'b010;
    req_op1   = (enc == 2'd1) ? 3'b100 : 3'b011;
    req_crm   = (enc == 2'd1) ? 4'b0100 : (enc == 2'd2) ? 4'b0011 : 4'b0100;
    if (enc == 2'd0) req_op1 = 3'b011;
    req_wdata = data;
    cur_el    = el;
    cfgv      = cfg;
    #1;
  endtask

  task automatic read_sel(input int s, input string tag, input logic [63:0] exp);
    if (s == 0)      drive(2'd3, 2'd2, 13'b000_000_000_00_00, 1'b0, 64'h0);
    else if (s == 1) drive(2'd3, 2'd1, 13'b101_000_000_00_00, 1'b0, 64'h0);
    else             drive(2'd2, 2'd2, 13'b010_010_000_00_00, 1'b0, 64'h0);
    check(tag, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  localparam logic [63:0] VA = 64'hA5A5_0000_1111_2222;
  localparam logic [63:0] VB = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] VC = 64'hFFFF_FFFF_0000_0001;

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
    req_op0 = '0; req_op1 = '0; req_crn = '0; req_crm = '0; req_op2 = '0;
    req_wdata = '0; cur_el = '0; cfgv = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R2: idle request shows no outcome
    #1;
    check("R2 idle outcome", 64'(act_oc()), 64'd0);
    // R13: all registers cleared by reset
    read_sel(0, "R13 sel0 reset", 64'h0);
    read_sel(1, "R13 sel1 reset", 64'h0);
    read_sel(2, "R13 sel2 reset", 64'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      logic ok;
      drive(v.el, v.enc, v.cfg, 1'b0, 64'h0);
      ok = (act_oc() == int'(v.oc));
      if (v.oc == 3'd2) ok = ok && (trap_to_hyp == v.tgt) && (trap_class == 6'h18); // R14
      if (v.oc == 3'd3) ok = ok && (mem_offset == 12'h168);
      if (v.oc == 3'd4) ok = ok && (reg_sel == v.sel);
      n_tests++;
      if (!ok) begin
        n_fail++;
        $display("FAIL R%0d row %0d actual oc=%0d tgt=%0b sel=%0d cls=%h off=%h expected oc=%0d tgt=%0b sel=%0d",
                 v.req, i, act_oc(), trap_to_hyp, reg_sel, trap_class, mem_offset, v.oc, v.tgt, v.sel);
      end
    end

    // R12: writes through each path, read back same cycle
    drive(2'd3, 2'd2, 13'b000_000_000_00_00, 1'b1, VA);
    check("R12 rdata zero on write", rdata, 64'h0);
    drive(2'd2, 2'd1, 13'b010_000_000_00_00, 1'b1, VB);
    drive(2'd2, 2'd2, 13'b010_010_000_00_00, 1'b1, VC);
    read_sel(0, "R12 sel0 written", VA);
    read_sel(1, "R12 sel1 written", VB);
    read_sel(2, "R12 sel2 written", VC);

    // R12: undefined write leaves sel1 unchanged
    drive(2'd0, 2'd1, 13'b000_000_000_00_00, 1'b1, 64'hDEAD);
    read_sel(1, "R12 undef write ignored", VB);

    // R9: redirected write goes out as memory request, registers untouched
    drive(2'd1, 2'd2, 13'b000_100_111_00_00, 1'b1, 64'hBEEF);
    check("R9 mem_write", 64'(mem_write), 64'd1);
    check("R9 mem_wdata", mem_wdata, 64'hBEEF);
    read_sel(0, "R12 redirected write ignored", VA);

    // R12: trapped write leaves sel0 unchanged
    drive(2'd0, 2'd2, 13'b000_000_000_00_00, 1'b1, 64'hCAFE);
    check("R14 trap class on write", 64'(trap_class), 64'h18);
    read_sel(0, "R12 trapped write ignored", VA);

    // R1/R12: write with valid low lands nowhere
    drive(2'd3, 2'd2, 13'b000_000_000_00_00, 1'b1, 64'h1234);
    req_valid = 1'b0;
    #1;
    check("R1 invalid no outcome", 64'(act_oc()), 64'd0);
    read_sel(0, "R12 invalid write ignored", VA);

    // R13: reset again clears written registers
    @(negedge clk); rst = 1'b1; req_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    read_sel(2, "R13 sel2 after second reset", 64'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule